// File: doc/BRIEF.md
# Circular Packet Stack Address Manager

This block produces RAM write addresses for a circular stack that stores a stream of variable-length data packets. Software sets a start address and an end address. Every accepted word goes to the next location in that range, and the range wraps from the end address back to the start address. Each packet begins at the location right after the final word of the packet before it, so packet starts move steadily around the stack.

A packet is closed automatically once its length comes within `MARGIN` words of the stack size. A packet therefore never reaches its own first word. Closing a packet raises a packet-ready event.

Three events are latched in sticky status bits:
- a fill-warning event, raised at a configurable length measured from the current packet start;
- an absolute address-match event;
- packet-ready.

The interrupt output is the OR of the enabled status bits. When the auto-restart control is set, a new packet opens at once after a packet is closed. When it is clear, the block holds until the host acknowledges. Words that arrive while it holds are dropped and flagged.

Top module: `stk_pkt_mgr`

## Requirements
- R1: The write address always lies between `cfg_start` and `cfg_end` inclusive. Successive accepted words use successive addresses, and the address after `cfg_end` is `cfg_start`.
- R2: After reset the current packet starts at `cfg_start` with length zero, all status bits are clear, `irq` is low and `last_status_addr` is zero.
- R3: After an accepted word brings the packet length to (stack size − `MARGIN`), the packet is closed. The next packet starts at the address right after that word, the length returns to zero, and status bit 0 (packet ready) is set.
- R4: An accepted status word loads its write address into `last_status_addr`. If both strobes are high in the same cycle, they count as one word, and that word is a status word.
- R5: When a word is accepted at the address `cfg_match_addr`, status bit 2 (address match) is set. This depends only on the absolute address, not on where the packet started.
- R6: When an accepted word brings the packet length to `cfg_fill_cnt`, status bit 1 (fill warning) is set. A `cfg_fill_cnt` of zero never triggers.
- R7: With `cfg_auto_restart` high, words keep being accepted without a gap across packet boundaries.
- R8: With `cfg_auto_restart` low, the block holds after a packet is closed. In that state a strobe is not accepted (`wr_en` low, address unchanged) and sets status bit 3 (overflow). A `host_ack` pulse ends the hold.
- R9: Status bits are sticky. Writing a one to the matching `irq_clr` bit clears a bit. A set event in the same cycle as a clear leaves the bit set.
- R10: `irq` is high exactly when a status bit among 0..2 is set and its `cfg_irq_en` bit (same index) is high. The overflow bit never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | AW | First address of the stack |
| cfg_end | input | AW | Last address of the stack |
| cfg_fill_cnt | input | AW+1 | Packet length that raises fill warning, 0 = off |
| cfg_match_addr | input | AW | Absolute address that raises address match |
| cfg_irq_en | input | 3 | Interrupt enables: [0] ready, [1] fill, [2] match |
| cfg_auto_restart | input | 1 | Open the next packet immediately after closing one |
| wr_data_stb | input | 1 | Payload word write request |
| wr_status_stb | input | 1 | End-of-message status word write request |
| host_ack | input | 1 | Host has serviced packet ready; ends a hold |
| irq_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| wr_en | output | 1 | Word accepted this cycle |
| wr_addr | output | AW | RAM address of the current word |
| last_status_addr | output | AW | Address of the latest status word |
| pkt_start_addr | output | AW | Start address of the current packet |
| irq_status | output | 4 | Sticky status: [0] ready, [1] fill, [2] match, [3] overflow |
| irq | output | 1 | OR of the enabled status bits 0..2 |

## Verification
The bench drives packets over the wrap point. A design that forgot to subtract the stack size, or that wrapped one word early, would put words outside the range or skip `cfg_start`. It then checks that each new packet begins one past the previous final word. An off-by-one in the close rule would shift every later packet start and every address after it. The fill-warning test uses a packet that does not start at `cfg_start`, which exposes a threshold measured against the stack start instead of the packet start. Further tests cover a simultaneous clear and set, masked enables, and dropped words in hold mode. These catch a clear that beats a set, an interrupt that ignores its enable, and a held block that still advances its address.

// File: rtl/stk_pkt_pkg.sv
// Package: shared status-bit indices for the circular packet stack manager.
// Assumes the status vector is four bits wide with the order given here.
package stk_pkt_pkg;
    localparam int ST_BITS    = 4;
    localparam int ST_READY   = 0;
    localparam int ST_FILL    = 1;
    localparam int ST_MATCH   = 2;
    localparam int ST_OVFL    = 3;
    localparam int IRQ_SRCS   = 3;

    typedef enum logic {PH_RUN = 1'b0, PH_HOLD = 1'b1} phase_t;
endpackage

// File: rtl/stk_addr_gen.sv
// Module: turns a packet start plus length offset into a physical stack
// address, and gives the address that follows it in circular order.
// Assumes cfg_start <= base <= cfg_end and off < stack size.
module stk_addr_gen #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic [AW:0]   size,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   off,
    output logic [AW-1:0] phys,
    output logic [AW-1:0] phys_next
);
    localparam int LW = AW + 1;

    logic [LW-1:0] sum;

    // Wrap base+offset back into the stack range.
    always_comb begin
        sum = {1'b0, base} + off;
        if (sum > {1'b0, cfg_end}) sum = sum - size;
        phys = sum[AW-1:0];
    end

    // Successor of the physical address, wrapping end to start.
    always_comb begin
        if (phys == cfg_end) phys_next = cfg_start;
        else                 phys_next = phys + 1'b1;
    end
endmodule

// File: rtl/stk_sticky.sv
// Module: a bank of sticky event bits with write-one-to-clear.
// Assumes set takes priority over a clear in the same cycle.
module stk_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One latched event bit; set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/stk_pkt_mgr.sv
// Module: circular packet stack address manager (top).
// Tracks the current packet start and length, closes a packet MARGIN
// words short of the stack size, and raises ready/fill/match events.
// Assumes cfg_start <= cfg_end, MARGIN >= 1, and config held stable
// while words flow.
module stk_pkt_mgr #(
    parameter int AW     = 8,
    parameter int MARGIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic [AW:0]   cfg_fill_cnt,
    input  logic [AW-1:0] cfg_match_addr,
    input  logic [2:0]    cfg_irq_en,
    input  logic          cfg_auto_restart,
    input  logic          wr_data_stb,
    input  logic          wr_status_stb,
    input  logic          host_ack,
    input  logic [3:0]    irq_clr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] last_status_addr,
    output logic [AW-1:0] pkt_start_addr,
    output logic [3:0]    irq_status,
    output logic          irq
);
    import stk_pkt_pkg::*;

    localparam int LW = AW + 1;
    localparam logic [LW-1:0] MARGIN_W = LW'(MARGIN);

    logic [LW-1:0] size;
    logic [LW-1:0] pkt_len;
    logic [LW-1:0] len_inc;
    logic [AW-1:0] addr_next;
    phase_t        phase;
    logic          any_stb;
    logic          closing;
    logic [ST_BITS-1:0] ev_set;

    // Stack size from the configured bounds.
    always_comb size = {1'b0, cfg_end} - {1'b0, cfg_start} + 1'b1;

    stk_addr_gen #(.AW(AW)) i_addr (
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .size      (size),
        .base      (pkt_start_addr),
        .off       (pkt_len),
        .phys      (wr_addr),
        .phys_next (addr_next)
    );

    // Accept decision, length step and close condition.
    always_comb begin
        any_stb = wr_data_stb | wr_status_stb;
        wr_en   = any_stb && (phase == PH_RUN);
        len_inc = pkt_len + 1'b1;
        closing = wr_en && (len_inc >= size - MARGIN_W);
    end

    // Event sources feeding the sticky status bank.
    always_comb begin
        ev_set           = '0;
        ev_set[ST_READY] = closing;
        ev_set[ST_FILL]  = wr_en && (cfg_fill_cnt != '0) && (len_inc == cfg_fill_cnt);
        ev_set[ST_MATCH] = wr_en && (wr_addr == cfg_match_addr);
        ev_set[ST_OVFL]  = any_stb && (phase == PH_HOLD);
    end

    // Packet start, length and run/hold phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_start_addr <= cfg_start;
            pkt_len        <= '0;
            phase          <= PH_RUN;
        end else if (closing) begin
            pkt_start_addr <= addr_next;
            pkt_len        <= '0;
            phase          <= cfg_auto_restart ? PH_RUN : PH_HOLD;
        end else begin
            if (wr_en) pkt_len <= len_inc;
            if (phase == PH_HOLD && host_ack) phase <= PH_RUN;
        end
    end

    // Address of the most recent status word.
    always_ff @(posedge clk) begin
        if (!rst_n)                     last_status_addr <= '0;
        else if (wr_en && wr_status_stb) last_status_addr <= wr_addr;
    end

    stk_sticky #(.N(ST_BITS)) i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (irq_clr),
        .q     (irq_status)
    );

    // Interrupt line: enabled event bits only.
    always_comb irq = |(irq_status[IRQ_SRCS-1:0] & cfg_irq_en);
endmodule

// File: rtl/stk_pkt_mgr_chk.sv
// Module: property checker for stk_pkt_mgr, attached with bind.
// Assumes the configuration is legal (cfg_start <= cfg_end).
module stk_pkt_mgr_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_start,
    input logic [AW-1:0] cfg_end,
    input logic [AW-1:0] cfg_match_addr,
    input logic          wr_data_stb,
    input logic          wr_status_stb,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] last_status_addr,
    input logic [AW-1:0] pkt_start_addr,
    input logic [3:0]    irq_status
);
    a_r1_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr >= cfg_start) && (wr_addr <= cfg_end));

    a_r4_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_status_stb) |=> (last_status_addr == $past(wr_addr)));

    a_r3_start_moves_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($stable(pkt_start_addr) || irq_status[0]));

    a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == cfg_match_addr)) |=> irq_status[2]);

    a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_data_stb || wr_status_stb) && !wr_en) |=> irq_status[3]);
endmodule

bind stk_pkt_mgr stk_pkt_mgr_chk #(.AW(AW)) i_stk_pkt_mgr_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_start        (cfg_start),
    .cfg_end          (cfg_end),
    .cfg_match_addr   (cfg_match_addr),
    .wr_data_stb      (wr_data_stb),
    .wr_status_stb    (wr_status_stb),
    .wr_en            (wr_en),
    .wr_addr          (wr_addr),
    .last_status_addr (last_status_addr),
    .pkt_start_addr   (pkt_start_addr),
    .irq_status       (irq_status)
);

// File: tb/test_stk_pkt_mgr.sv
// Bench: directed scenarios for stk_pkt_mgr, one task each.
module test_stk_pkt_mgr;
    localparam int AW     = 8;
    localparam int MARGIN = 4;
    localparam int START  = 16;
    localparam int ENDA   = 31;
    localparam int SIZE   = ENDA - START + 1;
    localparam int CLOSE  = SIZE - MARGIN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_start = AW'(START);
    logic [AW-1:0] cfg_end = AW'(ENDA);
    logic [AW:0]   cfg_fill_cnt = '0;
    logic [AW-1:0] cfg_match_addr = '0;
    logic [2:0]    cfg_irq_en = '0;
    logic          cfg_auto_restart = 1'b1;
    logic          wr_data_stb = 1'b0;
    logic          wr_status_stb = 1'b0;
    logic          host_ack = 1'b0;
    logic [3:0]    irq_clr = '0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] last_status_addr;
    logic [AW-1:0] pkt_start_addr;
    logic [3:0]    irq_status;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int exp_start = START;
    int exp_len   = 0;

    always #5 clk = ~clk;

    stk_pkt_mgr #(.AW(AW), .MARGIN(MARGIN)) i_stk_pkt_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_fill_cnt(cfg_fill_cnt), .cfg_match_addr(cfg_match_addr),
        .cfg_irq_en(cfg_irq_en), .cfg_auto_restart(cfg_auto_restart),
        .wr_data_stb(wr_data_stb), .wr_status_stb(wr_status_stb),
        .host_ack(host_ack), .irq_clr(irq_clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .last_status_addr(last_status_addr), .pkt_start_addr(pkt_start_addr),
        .irq_status(irq_status), .irq(irq)
    );

    function automatic int wrap(input int a);
        return (a > ENDA) ? a - SIZE : a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One word: checks address and accept, then advances the model.
    task automatic push(input bit st, input bit both);
        int a;
        @(negedge clk);
        wr_data_stb   = !st || both;
        wr_status_stb = st;
        #1;
        chk(wr_en == 1'b1, "R7 accept", int'(wr_en), 1);
        chk(int'(wr_addr) == wrap(exp_start + exp_len), "R1 address",
            int'(wr_addr), wrap(exp_start + exp_len));
        a = int'(wr_addr);
        @(negedge clk);
        wr_data_stb   = 1'b0;
        wr_status_stb = 1'b0;
        if (st) chk(int'(last_status_addr) == a, "R4 status addr", int'(last_status_addr), a);
        exp_len++;
        if (exp_len == CLOSE) begin
            exp_start = wrap(a + 1);
            exp_len   = 0;
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        irq_clr = 4'hF;
        @(negedge clk);
        irq_clr = 4'h0;
    endtask

    task automatic t_reset();
        chk(int'(wr_addr) == START, "R2 reset addr", int'(wr_addr), START);
        chk(int'(pkt_start_addr) == START, "R2 reset start", int'(pkt_start_addr), START);
        chk(irq_status == 4'h0, "R2 reset status", int'(irq_status), 0);
        chk(irq == 1'b0 && last_status_addr == '0, "R2 reset irq/last", int'(irq), 0);
    endtask

    task automatic t_first_packet();
        for (int i = 0; i < CLOSE - 2; i++) push(1'b0, 1'b0);
        chk(irq_status[0] == 1'b0, "R3 not closed early", int'(irq_status[0]), 0);
        push(1'b0, 1'b0);
        push(1'b1, 1'b0);
        chk(irq_status[0] == 1'b1, "R3 ready set", int'(irq_status[0]), 1);
        chk(int'(pkt_start_addr) == START + CLOSE, "R3 next start",
            int'(pkt_start_addr), START + CLOSE);
        chk(irq == 1'b0, "R10 masked", int'(irq), 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < CLOSE; i++) push(i == CLOSE - 1, 1'b0);
        chk(int'(pkt_start_addr) == exp_start, "R7 start after wrap",
            int'(pkt_start_addr), exp_start);
        clear_all();
        chk(irq_status == 4'h0, "R9 w1c", int'(irq_status), 0);
    endtask

    task automatic t_fill();
        cfg_fill_cnt = 5;
        cfg_irq_en   = 3'b010;
        for (int i = 0; i < 4; i++) push(1'b0, 1'b0);
        chk(irq_status[1] == 1'b0 && irq == 1'b0, "R6 before count", int'(irq_status[1]), 0);
        push(1'b0, 1'b0);
        chk(irq_status[1] == 1'b1, "R6 fill at count", int'(irq_status[1]), 1);
        chk(irq == 1'b1, "R10 fill enabled", int'(irq), 1);
        for (int i = 0; i < CLOSE - 5; i++) push(1'b0, 1'b0);
        cfg_fill_cnt = 0;
        clear_all();
    endtask

    task automatic t_match();
        cfg_irq_en     = 3'b100;
        cfg_match_addr = AW'(wrap(exp_start + 2));
        push(1'b0, 1'b0);
        push(1'b0, 1'b0);
        chk(irq_status[2] == 1'b0, "R5 not yet", int'(irq_status[2]), 0);
        push(1'b0, 1'b0);
        chk(irq_status[2] == 1'b1 && irq, "R5 match", int'(irq_status[2]), 1);
        // Set and clear in the same cycle: set wins.
        cfg_match_addr = AW'(wrap(exp_start + exp_len));
        @(negedge clk);
        wr_data_stb = 1'b1;
        irq_clr     = 4'b0100;
        @(negedge clk);
        wr_data_stb = 1'b0;
        irq_clr     = 4'h0;
        exp_len++;
        chk(irq_status[2] == 1'b1, "R9 set wins", int'(irq_status[2]), 1);
        clear_all();
        // Both strobes at once: one status word.
        push(1'b1, 1'b1);
        chk(int'(wr_addr) == wrap(exp_start + exp_len), "R4 one word",
            int'(wr_addr), wrap(exp_start + exp_len));
        cfg_irq_en = 3'b000;
    endtask

    task automatic t_hold();
        int held;
        cfg_auto_restart = 1'b0;
        while (exp_len != 0) push(1'b0, 1'b0);
        held = int'(wr_addr);
        @(negedge clk);
        wr_data_stb = 1'b1;
        #1;
        chk(wr_en == 1'b0, "R8 dropped", int'(wr_en), 0);
        @(negedge clk);
        wr_data_stb = 1'b0;
        chk(int'(wr_addr) == held, "R8 addr held", int'(wr_addr), held);
        chk(irq_status[3] == 1'b1 && irq == 1'b0, "R8 overflow, R10 no irq",
            int'(irq_status[3]), 1);
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        push(1'b0, 1'b0);
        chk(int'(pkt_start_addr) == exp_start, "R8 resume start", int'(pkt_start_addr), exp_start);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_packet();
        t_wrap();
        t_fill();
        t_match();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule